// File: doc/BRIEF.md
# Next-Block Stream Buffer Prefetcher

This unit sits on the refill path between a primary instruction cache and the unified cache one level below it. When the instruction cache misses, it hands the missing block address to the prefetcher. The prefetcher either answers straight from a one-entry stream buffer or fetches from the lower level. On a miss that finds nothing in the buffer, it fetches both the missing block and the next one. The missing block is returned to the cache, and the block after it is parked in the stream buffer.

A later miss that lands on the buffered block is answered from the buffer on the next cycle, with no lower-level access. The prefetcher then starts fetching the block after that one, so a straight run of instructions finds each following block already waiting. A miss to a block whose prefetch is still in flight waits for that response instead of asking again. A miss to an unrelated block throws away the buffer and its in-flight prefetch and starts a new pair. Block addresses are block numbers of `BLK_W` bits and wrap modulo 2^`BLK_W`. The lower level answers requests in the order it accepts them.

Top module: `nbp_top`

## Requirements
- R1: After reset, `busy`, `fill_valid` and `mem_req_valid` are all low.
- R2: A miss to block b that is neither buffered nor pending produces exactly two lower-level requests: first a demand for b with `mem_req_pf`=0, then a prefetch for b+1 with `mem_req_pf`=1.
- R3: A demand response is returned to the cache as a one-cycle `fill_valid` pulse, one cycle after `mem_rsp_valid`, carrying the missed block number and the response data.
- R4: A prefetch response is stored in the stream buffer and produces no fill; every accepted miss produces exactly one fill.
- R5: A miss to the block held valid in the stream buffer raises `fill_valid` in the cycle after `miss_req`, with the buffered data, and issues no demand request.
- R6: After a stream buffer hit on block b, the only lower-level request is a prefetch for b+1.
- R7: A miss to the block whose prefetch is still outstanding issues no new request for it; the fill carries that prefetch's data, and it is followed by a prefetch for the next block.
- R8: A miss to a different block while a prefetch is outstanding discards that prefetch's response, which yields no fill, and then issues a demand and a prefetch pair for the new block.
- R9: A miss that misses the stream buffer invalidates its contents, so a later miss to the formerly buffered block goes to the lower level as a demand.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's valid, block and kind stay unchanged in the next cycle.
- R11: `busy` is high in the cycle after an accepted miss and stays high until the miss has been filled and all its requests have been issued; the cache raises `miss_req` only while `busy` is low.
- R12: The next-block address wraps from 2^BLK_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | One-cycle miss strobe from the instruction cache |
| miss_blk | input | BLK_W | Block number of the missing block |
| busy | output | 1 | Miss in progress; no new miss accepted |
| fill_valid | output | 1 | One-cycle fill strobe toward the cache |
| fill_blk | output | BLK_W | Block number of the fill |
| fill_data | output | DATA_W | Block data of the fill |
| mem_req_valid | output | 1 | Request to the lower level is valid |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_blk | output | BLK_W | Requested block number |
| mem_req_pf | output | 1 | 1 = prefetch request, 0 = demand request |
| mem_rsp_valid | input | 1 | Response strobe from the lower level, in request order |
| mem_rsp_data | input | DATA_W | Response block data |

## Verification
Cold misses are swept over scattered block numbers, including the top block, under three request-ready patterns. This separates the ordering of the demand and prefetch requests from the handling of back-pressure. A run of consecutive misses crossing the address wrap shows that buffer hits are one-cycle fills followed by a single prefetch. Back-to-back misses to the next block and to an unrelated block are each repeated over a sweep of lower-level latencies, so the follow-up miss lands before, on, and after the prefetch's arrival. This tells apart waiting on a pending block, hitting a just-arrived one, and discarding an orphaned prefetch. A final pattern revisits a block that was evicted from the buffer to show it is fetched again.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEM_REQ,
    ST_PF_REQ,
    ST_DEM_RSP,
    ST_WAIT_PF,
    ST_DRAIN
  } nbp_state_e;
endpackage

// File: rtl/nbp_sbuf.sv
module nbp_sbuf #(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [BLK_W-1:0]  arm_blk,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [BLK_W-1:0]  sb_blk,
  output logic [DATA_W-1:0] sb_data,
  output logic              sb_valid,
  output logic              sb_pending
);
  logic [BLK_W-1:0]  blk_nx;
  logic [DATA_W-1:0] data_nx;
  logic              valid_nx, pend_nx;
  logic              data_en;

  always_comb begin
    blk_nx   = sb_blk;
    valid_nx = sb_valid;
    pend_nx  = sb_pending;
    data_en  = 1'b0;
    data_nx  = load_data;
    if (arm) begin
      blk_nx   = arm_blk;
      valid_nx = 1'b0;
      pend_nx  = 1'b1;
    end else if (load) begin
      valid_nx = 1'b1;
      pend_nx  = 1'b0;
      data_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_blk     <= '0;
      sb_valid   <= 1'b0;
      sb_pending <= 1'b0;
    end else begin
      sb_blk     <= blk_nx;
      sb_valid   <= valid_nx;
      sb_pending <= pend_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) sb_data <= data_nx;
  end

  // R5
  sb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sb_valid && sb_pending));

  // R4
  sb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !arm) |=> (sb_valid && sb_data == $past(load_data)));
endmodule

// File: rtl/nbp_fillreg.sv
module nbp_fillreg #(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [BLK_W-1:0]  set_blk,
  input  logic [DATA_W-1:0] set_data,
  output logic              fill_valid,
  output logic [BLK_W-1:0]  fill_blk,
  output logic [DATA_W-1:0] fill_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_valid <= 1'b0;
    else        fill_valid <= set;
  end

  always_ff @(posedge clk) begin
    if (set) begin
      fill_blk  <= set_blk;
      fill_data <= set_data;
    end
  end
endmodule

// File: rtl/nbp_ctrl.sv
module nbp_ctrl
  import nbp_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [BLK_W-1:0]  miss_blk,
  output logic              busy,
  input  logic              mem_req_ready,
  output logic              mem_req_valid,
  output logic [BLK_W-1:0]  mem_req_blk,
  output logic              mem_req_pf,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [BLK_W-1:0]  sb_blk,
  input  logic [DATA_W-1:0] sb_data,
  input  logic              sb_valid,
  input  logic              sb_pending,
  output logic              sb_arm,
  output logic [BLK_W-1:0]  sb_arm_blk,
  output logic              sb_load,
  output logic              fill_set,
  output logic [BLK_W-1:0]  fill_set_blk,
  output logic [DATA_W-1:0] fill_set_data
);
  nbp_state_e       state, st_nx;
  logic [BLK_W-1:0] cur_blk, cur_nx;
  logic             dem_out, dem_nx, pf_out, pf_nx;
  logic             pf_arrive, eff_valid, eff_pend;
  logic [DATA_W-1:0] eff_data;

  assign busy      = (state != ST_IDLE);
  assign pf_arrive = mem_rsp_valid && pf_out && !dem_out;
  assign eff_valid = sb_valid || pf_arrive;
  assign eff_pend  = sb_pending && !pf_arrive;
  assign eff_data  = pf_arrive ? mem_rsp_data : sb_data;

  always_comb begin
    st_nx         = state;
    cur_nx        = cur_blk;
    dem_nx        = dem_out;
    pf_nx         = pf_out;
    mem_req_valid = 1'b0;
    mem_req_blk   = cur_blk;
    mem_req_pf    = 1'b0;
    sb_arm        = 1'b0;
    sb_arm_blk    = cur_blk + 1'b1;
    sb_load       = 1'b0;
    fill_set      = 1'b0;
    fill_set_blk  = cur_blk;
    fill_set_data = mem_rsp_data;

    if (mem_rsp_valid) begin
      if (dem_out) begin
        fill_set = 1'b1;
        dem_nx   = 1'b0;
      end else if (pf_out) begin
        pf_nx = 1'b0;
        if (state == ST_WAIT_PF) begin
          fill_set = 1'b1;
          sb_arm   = 1'b1;
          st_nx    = ST_PF_REQ;
        end else if (state == ST_DRAIN) begin
          sb_arm = 1'b1;
          st_nx  = ST_DEM_REQ;
        end else begin
          sb_load = 1'b1;
        end
      end
    end

    unique case (state)
      ST_IDLE: begin
        if (miss_req) begin
          cur_nx     = miss_blk;
          sb_arm_blk = miss_blk + 1'b1;
          if (eff_valid && sb_blk == miss_blk) begin
            fill_set      = 1'b1;
            fill_set_blk  = miss_blk;
            fill_set_data = eff_data;
            sb_arm        = 1'b1;
            st_nx         = ST_PF_REQ;
          end else if (eff_pend && sb_blk == miss_blk) begin
            st_nx = ST_WAIT_PF;
          end else if (eff_pend) begin
            st_nx = ST_DRAIN;
          end else begin
            sb_arm = 1'b1;
            st_nx  = ST_DEM_REQ;
          end
        end
      end
      ST_DEM_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          dem_nx = 1'b1;
          st_nx  = ST_PF_REQ;
        end
      end
      ST_PF_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_blk   = sb_blk;
        mem_req_pf    = 1'b1;
        if (mem_req_ready) begin
          pf_nx = 1'b1;
          st_nx = dem_nx ? ST_DEM_RSP : ST_IDLE;
        end
      end
      ST_DEM_RSP: begin
        if (!dem_nx) st_nx = ST_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_blk <= '0;
      dem_out <= 1'b0;
      pf_out  <= 1'b0;
    end else begin
      state   <= st_nx;
      cur_blk <= cur_nx;
      dem_out <= dem_nx;
      pf_out  <= pf_nx;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_blk) && $stable(mem_req_pf)));

  // R2
  dem_then_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_pf) |=>
      (mem_req_valid && mem_req_pf &&
       mem_req_blk == BLK_W'($past(mem_req_blk) + 1'b1)));

  // R6
  pf_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_pf) |-> (sb_pending && !sb_valid && mem_req_blk == sb_blk));

  // R11
  miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> !busy);
endmodule

// File: rtl/nbp_top.sv
module nbp_top #(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [BLK_W-1:0]  miss_blk,
  output logic              busy,
  output logic              fill_valid,
  output logic [BLK_W-1:0]  fill_blk,
  output logic [DATA_W-1:0] fill_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [BLK_W-1:0]  mem_req_blk,
  output logic              mem_req_pf,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic [BLK_W-1:0]  sb_blk, sb_arm_blk, fill_set_blk;
  logic [DATA_W-1:0] sb_data, fill_set_data;
  logic              sb_valid, sb_pending, sb_arm, sb_load, fill_set;

  nbp_ctrl #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_req      (miss_req),
    .miss_blk      (miss_blk),
    .busy          (busy),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_blk   (mem_req_blk),
    .mem_req_pf    (mem_req_pf),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .sb_blk        (sb_blk),
    .sb_data       (sb_data),
    .sb_valid      (sb_valid),
    .sb_pending    (sb_pending),
    .sb_arm        (sb_arm),
    .sb_arm_blk    (sb_arm_blk),
    .sb_load       (sb_load),
    .fill_set      (fill_set),
    .fill_set_blk  (fill_set_blk),
    .fill_set_data (fill_set_data)
  );

  nbp_sbuf #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_sbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (sb_arm),
    .arm_blk    (sb_arm_blk),
    .load       (sb_load),
    .load_data  (mem_rsp_data),
    .sb_blk     (sb_blk),
    .sb_data    (sb_data),
    .sb_valid   (sb_valid),
    .sb_pending (sb_pending)
  );

  nbp_fillreg #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .set        (fill_set),
    .set_blk    (fill_set_blk),
    .set_data   (fill_set_data),
    .fill_valid (fill_valid),
    .fill_blk   (fill_blk),
    .fill_data  (fill_data)
  );

  // R5
  sb_hit_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !busy && sb_valid && sb_blk == miss_blk) |=>
      (fill_valid && fill_blk == $past(miss_blk) && fill_data == $past(sb_data)));

  // R3
  fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
endmodule

// File: tb/test_nbp_top.sv
module test_nbp_top;
  localparam int BW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_req;
  logic [BW-1:0] miss_blk;
  logic          busy, fill_valid, mem_req_valid, mem_req_ready, mem_req_pf;
  logic          mem_rsp_valid;
  logic [BW-1:0] fill_blk, mem_req_blk;
  logic [DW-1:0] fill_data, mem_rsp_data;

  always #4 clk = ~clk;

  nbp_top #(.BLK_W(BW), .DATA_W(DW)) i_nbp_top (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_blk(miss_blk),
    .busy(busy), .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_blk(mem_req_blk), .mem_req_pf(mem_req_pf),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int total = 0, bad = 0, cyc = 0, nfill = 0, hold_viol = 0;
  int q_wr = 0, q_rd = 0, lat_cfg = 0, lat_cnt = 0, ready_mode = 0, nlog = 0;
  logic [BW-1:0] q_blk [0:7];
  logic [BW-1:0] log_blk [0:63];
  logic          log_pf  [0:63];
  logic          prev_stall = 1'b0;
  logic [BW-1:0] prev_blk = '0;
  bit            done = 0;

  function automatic logic [DW-1:0] word_of(input logic [BW-1:0] b);
    return {b, 8'hA5, ~b, b ^ 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lower-level model: accept at posedge, respond in order at negedge
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall && !(mem_req_valid && mem_req_blk == prev_blk)) hold_viol++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_blk   = mem_req_blk;
      if (mem_req_valid && mem_req_ready) begin
        q_blk[q_wr % 8] = mem_req_blk;
        q_wr++;
        if (nlog < 64) begin
          log_blk[nlog] = mem_req_blk;
          log_pf[nlog]  = mem_req_pf;
          nlog++;
        end
      end
      if (fill_valid) nfill++;
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: mem_req_ready = 1'b1;
      1: mem_req_ready = (cyc % 2) == 0;
      default: mem_req_ready = (cyc % 3) != 0;
    endcase
    mem_rsp_valid = 1'b0;
    if (q_wr > q_rd) begin
      if (lat_cnt >= lat_cfg) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = word_of(q_blk[q_rd % 8]);
        q_rd++;
        lat_cnt = 0;
      end else begin
        lat_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_miss(input logic [BW-1:0] b, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    miss_req = 1'b1;
    miss_blk = b;
    @(negedge clk);
    miss_req = 1'b0;
    chk(busy == 1'b1, "R11 busy after miss", busy, 1);
    lat = 1;
    while (!fill_valid && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    chk(fill_blk == b && fill_data == word_of(b), "R3 fill content",
        {fill_blk, fill_data}, {b, word_of(b)});
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy || q_wr != q_rd) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_log(input int idx, input logic [BW-1:0] b, input logic pf, input string req);
    chk(idx < nlog && log_blk[idx] == b && log_pf[idx] == pf, req,
        {log_blk[idx], 7'd0, log_pf[idx]}, {b, 7'd0, pf});
  endtask

  initial begin
    int lat, f0;
    logic [BW-1:0] b;
    logic [BW-1:0] cold_list [0:5];
    cold_list[0] = 8'd0;  cold_list[1] = 8'd37; cold_list[2] = 8'd128;
    cold_list[3] = 8'd255; cold_list[4] = 8'd200; cold_list[5] = 8'd91;
    miss_req = 1'b0;
    miss_blk = '0;
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy, "R1 busy", busy, 0);
    chk(!fill_valid, "R1 fill_valid", fill_valid, 0);
    chk(!mem_req_valid, "R1 mem_req_valid", mem_req_valid, 0);

    // R2 / R3 / R4 / R12: cold misses under three ready patterns
    for (int i = 0; i < 6; i++) begin
      ready_mode = i % 3;
      lat_cfg = i;
      b = cold_list[i];
      nlog = 0;
      f0 = nfill;
      do_miss(b, lat);
      settle();
      chk(nlog == 2, "R2 request count", nlog, 2);
      chk_log(0, b, 1'b0, "R2 demand first");
      chk_log(1, BW'(b + 1), 1'b1, "R2 R12 prefetch next");
      chk(nfill == f0 + 1, "R4 one fill per miss", nfill, f0 + 1);
    end

    // R5 / R6 / R12: sequential run across the wrap
    ready_mode = 1;
    lat_cfg = 2;
    do_miss(8'd250, lat);
    settle();
    for (int j = 0; j < 12; j++) begin
      b = BW'(251 + j);
      nlog = 0;
      f0 = nfill;
      do_miss(b, lat);
      chk(lat == 1, "R5 buffer hit in one cycle", lat, 1);
      settle();
      chk(nlog == 1, "R6 single request", nlog, 1);
      chk_log(0, BW'(b + 1), 1'b1, "R6 R12 prefetch after hit");
      chk(nfill == f0 + 1, "R4 no fill from prefetch", nfill, f0 + 1);
    end

    // R7: next-block miss right behind a cold miss, latency sweep
    for (int l = 0; l < 8; l++) begin
      ready_mode = l % 2;
      lat_cfg = l;
      b = BW'(100 + 10 * l);
      nlog = 0;
      f0 = nfill;
      do_miss(b, lat);
      do_miss(BW'(b + 1), lat);
      settle();
      chk(nlog == 3, "R7 no re-request", nlog, 3);
      chk_log(0, b, 1'b0, "R7 demand");
      chk_log(1, BW'(b + 1), 1'b1, "R7 prefetch");
      chk_log(2, BW'(b + 2), 1'b1, "R7 follow-on prefetch");
      chk(nfill == f0 + 2, "R7 fill count", nfill, f0 + 2);
    end

    // R8: unrelated miss while prefetch outstanding, latency sweep
    for (int l = 0; l < 8; l++) begin
      ready_mode = 1 + (l % 2);
      lat_cfg = l;
      b = BW'(20 + 3 * l);
      nlog = 0;
      f0 = nfill;
      do_miss(b, lat);
      do_miss(BW'(b + 60), lat);
      settle();
      chk(nlog == 4, "R8 request count", nlog, 4);
      chk_log(2, BW'(b + 60), 1'b0, "R8 new demand");
      chk_log(3, BW'(b + 61), 1'b1, "R8 new prefetch");
      chk(nfill == f0 + 2, "R8 discarded prefetch gives no fill", nfill, f0 + 2);
    end

    // R9: buffer contents invalidated by a miss elsewhere
    ready_mode = 0;
    lat_cfg = 3;
    do_miss(8'd70, lat);
    settle();
    do_miss(8'd150, lat);
    settle();
    nlog = 0;
    do_miss(8'd71, lat);
    settle();
    chk(lat > 1, "R9 no stale hit", lat, 2);
    chk_log(0, 8'd71, 1'b0, "R9 demand for evicted block");
    chk_log(1, 8'd72, 1'b1, "R9 prefetch");

    // R10
    chk(hold_viol == 0, "R10 request held under back-pressure", hold_viol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule